// File: doc/BRIEF.md
# Soft mute gain ramp for stereo audio samples

The block sits in a stereo sample path in front of a digital-to-analog converter. It scales each 24-bit two's-complement sample pair by a gain value. The gain falls smoothly to zero while a mute request is held and climbs back to unity once the request is dropped. Each sample-valid strobe marks one frame and advances the gain by one step. The size of that step depends on a two-bit speed code, so the whole ramp takes a fixed number of frames. That number doubles in double-rate operation and doubles again in quad-rate operation.

Dropping the request while the gain is still moving turns the ramp around from wherever it stands. The gain then goes back to unity at the same rate, with no restart and no jump. A single flag reports that the gain has reached zero, which means both output samples are exactly zero.

Top module: `soft_mute_ramp`

## Requirements
- R1: While reset is held low and until the first strobe after it, both output samples are 0, the zero-gain flag is low and the output strobe is low. The gain starts at unity, so the first frame after reset passes its input unchanged.
- R2: At unity gain and with mute not requested, each output sample equals its input sample. The result appears on the clock edge that samples the input strobe.
- R3: Speed code 2'b00 selects normal rate. Starting from unity with mute requested, the gain reaches zero on exactly the 1024th strobe, and the zero-gain flag rises with that frame's output and not before.
- R4: Speed code 2'b01 selects double rate. The full ramp down takes exactly 2048 strobes.
- R5: Speed code 2'b10 selects quad rate. The full ramp down takes exactly 4096 strobes. Code 2'b11 behaves the same as 2'b10.
- R6: Starting from zero gain with mute released, the output equals the input again on exactly the same number of strobes that the ramp down took in that speed mode, and not one strobe earlier.
- R7: If mute is released partway down, the gain rises from its current value at the same rate. After N muted strobes, exactly N released strobes restore unity.
- R8: Let g be the gain, running from 0 to 4096, where 4096 is unity. Each output equals input × g / 4096, truncated toward zero. At g = 2048, an input of -3 gives -1 and an input of 8388607 gives 4194303.
- R9: The mute request is sampled only on strobe cycles. Its level between strobes has no effect on the gain.
- R10: The gain saturates. Further muted strobes at zero gain keep the output at 0 and the flag high, and further released strobes at unity keep the output equal to the input.
- R11: The output strobe is high for exactly one cycle after each input strobe. Outputs and the flag hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe per frame |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| mute_req | input | 1 | Mute request, active high |
| speed_mode | input | 2 | 00 normal, 01 double, 10/11 quad |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| muted | output | 1 | High when the applied gain is zero |

## Verification
The hardest states to reach are the two saturation boundaries in the quad-rate modes and a reversal from a gain that is not at either end. Reaching them takes thousands of strobes with the request held steady. The bench drives long runs of frames and compares every frame with a gain model built from the step sizes. It checks the exact strobe on which the flag rises and the exact strobe on which the output matches the input again. For the reversal, it stops a muted run after a chosen count and counts the released frames back. Request toggles between strobes are driven on idle cycles and then shown to have had no effect on the next frame's output.

// File: rtl/smr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the soft mute ramp.
// Assumes the speed code is a 2-bit field driven by the host clocking logic.
package smr_pkg;

    // Speed code; the two top codes both select the slowest ramp.
    typedef enum logic [1:0] {
        SPD_NORMAL   = 2'b00,
        SPD_DOUBLE   = 2'b01,
        SPD_QUAD     = 2'b10,
        SPD_QUAD_ALT = 2'b11
    } speed_e;

    // Number of frames a full ramp lasts for a given speed code.
    function automatic int unsigned ramp_frames(speed_e s, int unsigned base);
        case (s)
            SPD_NORMAL: return base;
            SPD_DOUBLE: return base * 2;
            default:    return base * 4;
        endcase
    endfunction

endpackage

// File: rtl/smr_step_sel.sv
`timescale 1ns/1ps
// Picks the per-frame gain step for the current speed code.
// Assumes UNITY is divisible by 4*RAMP_BASE so every step is an exact integer.
module smr_step_sel #(
    parameter int GAIN_W    = 12,
    parameter int RAMP_BASE = 1024
) (
    input  logic [1:0]      speed_mode,
    output logic [GAIN_W:0] step
);
    import smr_pkg::*;

    localparam int UNITY  = 1 << GAIN_W;
    localparam int STEP_N = UNITY / int'(ramp_frames(SPD_NORMAL, RAMP_BASE));
    localparam int STEP_D = UNITY / int'(ramp_frames(SPD_DOUBLE, RAMP_BASE));
    localparam int STEP_Q = UNITY / int'(ramp_frames(SPD_QUAD, RAMP_BASE));

    // Map the speed code to the step that covers the range in its frame count.
    always_comb begin
        case (speed_e'(speed_mode))
            SPD_NORMAL: step = (GAIN_W+1)'(STEP_N);
            SPD_DOUBLE: step = (GAIN_W+1)'(STEP_D);
            default:    step = (GAIN_W+1)'(STEP_Q);
        endcase
    end

endmodule

// File: rtl/smr_gain_ctrl.sv
`timescale 1ns/1ps
// Holds the gain counter (0 .. 2**GAIN_W) and moves it one step per frame.
// The gain goes down while mute is requested and up otherwise, saturating at
// both ends. The request only matters on strobe cycles.
module smr_gain_ctrl #(
    parameter int GAIN_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_stb,
    input  logic            mute_req,
    input  logic [GAIN_W:0] step,
    output logic [GAIN_W:0] gain_q,
    output logic [GAIN_W:0] gain_nxt
);
    localparam logic [GAIN_W:0] UNITY_L = (GAIN_W+1)'(1 << GAIN_W);

    logic [GAIN_W:0] headroom;

    // Candidate gain for this frame, clamped to the valid range.
    always_comb begin
        headroom = UNITY_L - gain_q;
        if (mute_req) begin
            gain_nxt = (gain_q > step) ? gain_q - step : '0;
        end else begin
            gain_nxt = (headroom > step) ? gain_q + step : UNITY_L;
        end
    end

    // Commit the candidate only on a frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= UNITY_L;
        end else if (frame_stb) begin
            gain_q <= gain_nxt;
        end
    end

endmodule

// File: rtl/smr_scaler.sv
`timescale 1ns/1ps
// Multiplies one channel sample by the gain and divides by 2**GAIN_W,
// truncating toward zero. The result is registered on the frame strobe.
// Assumes the gain never exceeds 2**GAIN_W, so the quotient fits DATA_W bits.
module smr_scaler #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_stb,
    input  logic signed [DATA_W-1:0] sample_in,
    input  logic        [GAIN_W:0]   gain,
    output logic signed [DATA_W-1:0] sample_out
);
    localparam int PW = DATA_W + GAIN_W;

    logic signed [PW-1:0]     a_ext;
    logic signed [PW-1:0]     g_ext;
    logic signed [PW-1:0]     prod;
    logic                     frac_nz;
    logic signed [DATA_W-1:0] quot;

    // Full-precision product, then a floor shift corrected toward zero.
    always_comb begin
        a_ext   = PW'(sample_in);
        g_ext   = PW'($signed({1'b0, gain}));
        prod    = a_ext * g_ext;
        frac_nz = |prod[GAIN_W-1:0];
        quot    = prod[PW-1:GAIN_W] + DATA_W'(prod[PW-1] & frac_nz);
    end

    // Register the scaled sample once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
        end else if (frame_stb) begin
            sample_out <= quot;
        end
    end

endmodule

// File: rtl/soft_mute_ramp.sv
`timescale 1ns/1ps
// Soft mute ramp for a stereo stream of two's-complement samples.
// One in_valid strobe per frame moves the gain one step toward zero (mute
// requested) or unity (released). Outputs follow one cycle after the strobe.
// Assumes in_valid is a single-cycle pulse per frame.
module soft_mute_ramp #(
    parameter int DATA_W    = 24,
    parameter int GAIN_W    = 12,
    parameter int RAMP_BASE = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic                     mute_req,
    input  logic [1:0]               speed_mode,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right,
    output logic                     muted
);
    localparam int NUM_CH = 2;

    logic [GAIN_W:0]          step;
    logic [GAIN_W:0]          gain_q;
    logic [GAIN_W:0]          gain_nxt;
    logic signed [DATA_W-1:0] ch_in  [NUM_CH];
    logic signed [DATA_W-1:0] ch_out [NUM_CH];

    smr_step_sel #(.GAIN_W(GAIN_W), .RAMP_BASE(RAMP_BASE)) step_sel_i (
        .speed_mode (speed_mode),
        .step       (step)
    );

    smr_gain_ctrl #(.GAIN_W(GAIN_W)) gain_ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (in_valid),
        .mute_req  (mute_req),
        .step      (step),
        .gain_q    (gain_q),
        .gain_nxt  (gain_nxt)
    );

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        smr_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) scaler_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_stb  (in_valid),
            .sample_in  (ch_in[ch]),
            .gain       (gain_nxt),
            .sample_out (ch_out[ch])
        );
    end

    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];

    // Output strobe trails the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Zero-gain flag tracks the gain applied to the registered samples.
    always_ff @(posedge clk) begin
        if (!rst_n)        muted <= 1'b0;
        else if (in_valid) muted <= (gain_nxt == '0);
    end

endmodule

// File: rtl/soft_mute_ramp_chk.sv
`timescale 1ns/1ps
// Property checker for soft_mute_ramp, attached through bind.
// Observes the ports and the committed gain register.
module soft_mute_ramp_chk #(
    parameter int DATA_W    = 24,
    parameter int GAIN_W    = 12,
    parameter int RAMP_BASE = 1024
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_left,
    input logic signed [DATA_W-1:0] in_right,
    input logic                     mute_req,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_left,
    input logic signed [DATA_W-1:0] out_right,
    input logic                     muted,
    input logic [GAIN_W:0]          gain
);
    localparam int UNITY    = 1 << GAIN_W;
    localparam int MAX_STEP = UNITY / RAMP_BASE;

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right) && $stable(muted));

    // R3
    muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        muted |-> (out_left == '0) && (out_right == '0));

    // R2
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (int'(gain) == UNITY) |-> (out_left == $past(in_left)) && (out_right == $past(in_right)));

    // R7
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (int'(gain) <= int'($past(gain)) + MAX_STEP) && (int'($past(gain)) <= int'(gain) + MAX_STEP));

    // R9
    idle_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(gain));

    // R6
    rise_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mute_req |=> int'(gain) >= int'($past(gain)));

    // R3
    fall_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mute_req |=> int'(gain) <= int'($past(gain)));

    // R10
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> int'(gain) <= UNITY);

endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .RAMP_BASE(RAMP_BASE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .mute_req  (mute_req),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .muted     (muted),
    .gain      (gain_q)
);

// File: tb/soft_mute_ramp_tb.sv
`timescale 1ns/1ps
// Directed bench for soft_mute_ramp: one task per scenario.
module soft_mute_ramp_tb_top;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [23:0]  in_left = '0;
    logic signed [23:0]  in_right = '0;
    logic                mute_req = 1'b0;
    logic [1:0]          speed_mode = 2'b00;
    logic                out_valid;
    logic signed [23:0]  out_left;
    logic signed [23:0]  out_right;
    logic                muted;

    int checks = 0;
    int errors = 0;
    int model_g = 4096;

    always #2.5 clk = ~clk;

    soft_mute_ramp dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .mute_req(mute_req), .speed_mode(speed_mode),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .muted(muted)
    );

    function automatic longint scaled(int v, int g);
        longint p = longint'(v) * longint'(g);
        return p / 4096;
    endfunction

    function automatic int step_of(logic [1:0] md);
        return (md == 2'b00) ? 4 : (md == 2'b01) ? 2 : 1;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one frame, advance the model gain, and check the outputs.
    task automatic do_frame(int l, int r, bit m, logic [1:0] md, string req);
        @(negedge clk);
        in_valid = 1'b1; in_left = 24'(l); in_right = 24'(r);
        mute_req = m; speed_mode = md;
        if (m) model_g = (model_g > step_of(md)) ? model_g - step_of(md) : 0;
        else   model_g = (4096 - model_g > step_of(md)) ? model_g + step_of(md) : 4096;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && longint'(out_left) == scaled(l, model_g)
            && longint'(out_right) == scaled(r, model_g) && muted == (model_g == 0),
            req, "frame left", longint'(out_left), scaled(l, model_g));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_left == 0 && out_right == 0 && !muted && !out_valid, "R1",
            "reset outputs", longint'(out_left), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_left == 0 && !muted && !out_valid, "R1", "post reset idle",
            longint'(out_left), 0);
        model_g = 4096;
        do_frame(1234, -5678, 1'b0, 2'b00, "R1");
        chk(out_left == 24'sd1234, "R1", "first frame unity", longint'(out_left), 1234);
    endtask

    task automatic t_pass();
        do_frame(8388607, -8388608, 1'b0, 2'b00, "R2");
        chk(out_right == -24'sd8388608, "R2", "negative full scale", longint'(out_right), -8388608);
        do_frame(-1, 0, 1'b0, 2'b01, "R2");
        do_frame(24'h123456, -99, 1'b0, 2'b10, "R2");
        chk(out_left == 24'sh123456, "R2", "pattern", longint'(out_left), 24'h123456);
        // R11: outputs hold and strobe drops while inputs move without a strobe
        @(negedge clk);
        in_left = 24'sd777; mute_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(!out_valid && out_left == 24'sh123456, "R11", "hold between strobes",
            longint'(out_left), 24'h123456);
        mute_req = 1'b0;
    endtask

    task automatic t_ramp(logic [1:0] md, int n, string req);
        chk(model_g == 4096, req, "start at unity", model_g, 4096);
        for (int k = 1; k <= n; k++) begin
            do_frame(8388607 - k * 37, -8388608 + k * 53, 1'b1, md, req);
            if (k == n - 1) chk(!muted, req, "flag early", muted, 0);
            if (k == n)     chk(muted && out_left == 0, req, "flag at end", muted, 1);
        end
        for (int k = 1; k <= n; k++) begin
            do_frame(5000000, -4000001, 1'b0, md, "R6");
            if (k == n - 1) chk(out_left != 24'sd5000000, "R6", "not yet unity",
                                longint'(out_left), scaled(5000000, model_g));
            if (k == n)     chk(out_left == 24'sd5000000 && out_right == -24'sd4000001,
                                "R6", "back at unity", longint'(out_left), 5000000);
        end
    endtask

    task automatic t_scale();
        for (int k = 1; k <= 511; k++) do_frame(k, -k, 1'b1, 2'b00, "R8");
        do_frame(-3, 8388607, 1'b1, 2'b00, "R8");
        chk(out_left == -24'sd1, "R8", "neg truncates toward zero", longint'(out_left), -1);
        chk(out_right == 24'sd4194303, "R8", "pos truncates", longint'(out_right), 4194303);
        for (int k = 1; k <= 512; k++) do_frame(-8388608, 3, 1'b0, 2'b00, "R8");
    endtask

    task automatic t_reverse();
        for (int k = 1; k <= 300; k++) do_frame(1000000, -1000000, 1'b1, 2'b00, "R7");
        for (int k = 1; k <= 300; k++) begin
            do_frame(1000000, -1000000, 1'b0, 2'b00, "R7");
            if (k == 299) chk(out_left == 24'sd999023, "R7", "one step short",
                              longint'(out_left), 999023);
            if (k == 300) chk(out_left == 24'sd1000000, "R7", "restored",
                              longint'(out_left), 1000000);
        end
    endtask

    task automatic t_strobe_only();
        @(negedge clk);
        mute_req = 1'b1;
        repeat (10) @(negedge clk);
        do_frame(2222222, -2222222, 1'b0, 2'b00, "R9");
        chk(out_left == 24'sd2222222, "R9", "idle request ignored", longint'(out_left), 2222222);
        @(negedge clk);
        mute_req = 1'b0;
        repeat (5) @(negedge clk);
        do_frame(4096000, 0, 1'b1, 2'b00, "R9");
        chk(out_left == 24'sd4092000, "R9", "strobed request applied", longint'(out_left), 4092000);
        do_frame(4096000, 0, 1'b0, 2'b00, "R9");
    endtask

    task automatic t_saturate();
        for (int k = 1; k <= 1030; k++) do_frame(3000000, -3000000, 1'b1, 2'b00, "R10");
        chk(muted && out_left == 0 && out_right == 0, "R10", "held at zero", longint'(out_left), 0);
        for (int k = 1; k <= 1030; k++) do_frame(3000000, -3000000, 1'b0, 2'b00, "R10");
        chk(out_left == 24'sd3000000 && !muted, "R10", "held at unity", longint'(out_left), 3000000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pass();
        t_ramp(2'b00, 1024, "R3");
        t_ramp(2'b01, 2048, "R4");
        t_ramp(2'b10, 4096, "R5");
        t_ramp(2'b11, 4096, "R5");
        t_scale();
        t_reverse();
        t_strobe_only();
        t_saturate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule